// File: doc/BRIEF.md
# Video Parity Error Monitor

The monitor sits on the receive side of a serial video link, after the word has been deserialized and checked. Each received word comes with a valid strobe and a parity-fail indication. The monitor counts failing words in a 16-bit saturating counter. It compares that count against a 16-bit limit, which software supplies as two separate bytes. A second saturating counter records mismatches reported by a pseudo-random pattern checker during link test.

Both counts are visible on output ports, so a register file can return them to software. When software reads either count, it strobes a per-counter read input, and the counter clears. If nobody reads a counter, errors from one frame keep adding to the count from earlier frames.

A small cause-tracking state machine drives a single active-low error flag. The flag is asserted whenever any error cause is present. It is released in the same cycle that the last cause disappears.

The state machine has four states:

- `CAUSE_NONE`: no cause is present, and the flag is high.
- `CAUSE_PAR`: the parity count exceeds the limit.
- `CAUSE_PRBS`: the pattern count is non-zero.
- `CAUSE_BOTH`: both of the above hold.

On every clock edge, the machine moves to the state that matches the counter values being loaded at that edge and the limit present at that edge. Any state can reach any other state in one step. The transitions are:

- raise-parity: NONE→PAR, PRBS→BOTH.
- raise-pattern: NONE→PRBS, PAR→BOTH.
- drop-parity: PAR→NONE, BOTH→PRBS.
- drop-pattern: PRBS→NONE, BOTH→PAR.
- swap: PAR↔PRBS.
- a direct jump between NONE and BOTH.

Top module: `vid_parity_mon`

## Requirements
- R1: While reset is asserted and after it is released, both counts read zero and `err_n` is high.
- R2: At each clock edge where `word_vld` and `par_fail` are both 1, the parity count grows by exactly one. A `par_fail` without `word_vld` has no effect. No other input moves the count, except the parity read strobe.
- R3: Both counters saturate at their all-ones value and never wrap. The parity counter stops at 65535, and the pattern counter (8 bits by default) stops at 255.
- R4: `err_n` is 0 when the parity count is strictly greater than the limit. A count equal to the limit, or below it, is not a parity cause.
- R5: The limit is `{lim_hi, lim_lo}`: `lim_hi` supplies bits 15:8 and `lim_lo` supplies bits 7:0.
- R6: Each edge with `prbs_err` = 1 increments the pattern count. While the pattern count is non-zero, `err_n` is 0.
- R7: `rd_par` = 1 at an edge clears the parity count. If a failing valid word arrives at that same edge, the count becomes 1, so that error is not lost.
- R8: `rd_prbs` = 1 at an edge clears the pattern count. If a pattern error arrives at that same edge, the count becomes 1.
- R9: `err_n` returns high in the same cycle that the counts change so that no cause remains. If another cause is still present, `err_n` stays low.
- R10: Without a read strobe, counts from separate bursts, with idle cycles between them, add up.
- R11: `err_n` is registered. A change of the limit alone changes `err_n` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | A received word is present this cycle |
| par_fail | input | 1 | The present word failed its parity check |
| prbs_err | input | 1 | The pattern checker saw a mismatch this cycle |
| lim_lo | input | 8 | Limit bits 7:0 |
| lim_hi | input | 8 | Limit bits 15:8 |
| rd_par | input | 1 | Read strobe for the parity count (clears it) |
| rd_prbs | input | 1 | Read strobe for the pattern count (clears it) |
| par_cnt | output | 16 | Parity failure count |
| prbs_cnt | output | 8 | Pattern mismatch count |
| err_n | output | 1 | Error flag, active low |

## Verification
On every cycle, the assertions check the following:

- The parity count moves one step per failing valid word, and holds otherwise.
- A read clears the parity count.
- A saturated count never wraps.
- A non-zero pattern count always holds `err_n` low.
- `err_n` always matches the counts and the limit from the preceding edge.

Only the bench scenarios can show the rest:

- the byte order of the limit;
- the equal-to-limit boundary;
- the behaviour of reading while an error arrives in the same cycle;
- accumulation across separated bursts;
- the long climb to 65535.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_PAR  = 2'b01,
        CAUSE_PRBS = 2'b10,
        CAUSE_BOTH = 2'b11
    } cause_e;
endpackage

// File: rtl/vpm_sat_counter.sv
module vpm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    always_comb begin
        if (clr)
            cnt_nxt = hit ? ONE : ZERO;
        else if (hit && cnt != MAXV)
            cnt_nxt = cnt + ONE;
        else
            cnt_nxt = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= ZERO;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/vpm_cause_fsm.sv
module vpm_cause_fsm
    import vpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic par_over_nxt,
    input  logic prbs_nz_nxt,
    output logic err_n
);
    cause_e state, state_nxt;

    always_comb begin
        unique case ({prbs_nz_nxt, par_over_nxt})
            2'b00: state_nxt = CAUSE_NONE;
            2'b01: state_nxt = CAUSE_PAR;
            2'b10: state_nxt = CAUSE_PRBS;
            2'b11: state_nxt = CAUSE_BOTH;
            default: state_nxt = CAUSE_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAUSE_NONE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            CAUSE_NONE: err_n = 1'b1;
            CAUSE_PAR:  err_n = 1'b0;
            CAUSE_PRBS: err_n = 1'b0;
            CAUSE_BOTH: err_n = 1'b0;
            default:    err_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/vid_parity_mon.sv
module vid_parity_mon #(
    parameter int BYTE_W = 8,
    parameter int PRBS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_vld,
    input  logic                par_fail,
    input  logic                prbs_err,
    input  logic [BYTE_W-1:0]   lim_lo,
    input  logic [BYTE_W-1:0]   lim_hi,
    input  logic                rd_par,
    input  logic                rd_prbs,
    output logic [2*BYTE_W-1:0] par_cnt,
    output logic [PRBS_W-1:0]   prbs_cnt,
    output logic                err_n
);
    localparam int PAR_W = 2 * BYTE_W;

    logic [PAR_W-1:0]  par_nxt;
    logic [PRBS_W-1:0] prbs_nxt;
    logic [PAR_W-1:0]  limit;
    logic              par_hit;

    assign par_hit = word_vld & par_fail;
    assign limit   = {lim_hi, lim_lo};

    vpm_sat_counter #(.W(PAR_W)) u_par_cnt (
        .clk(clk), .rst_n(rst_n), .hit(par_hit), .clr(rd_par),
        .cnt(par_cnt), .cnt_nxt(par_nxt)
    );

    vpm_sat_counter #(.W(PRBS_W)) u_prbs_cnt (
        .clk(clk), .rst_n(rst_n), .hit(prbs_err), .clr(rd_prbs),
        .cnt(prbs_cnt), .cnt_nxt(prbs_nxt)
    );

    vpm_cause_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .par_over_nxt(par_nxt > limit),
        .prbs_nz_nxt(prbs_nxt != '0),
        .err_n(err_n)
    );
endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
    parameter int BYTE_W = 8,
    parameter int PRBS_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                word_vld,
    input logic                par_fail,
    input logic                prbs_err,
    input logic [BYTE_W-1:0]   lim_lo,
    input logic [BYTE_W-1:0]   lim_hi,
    input logic                rd_par,
    input logic                rd_prbs,
    input logic [2*BYTE_W-1:0] par_cnt,
    input logic [PRBS_W-1:0]   prbs_cnt,
    input logic                err_n
);
    localparam int PAR_W = 2 * BYTE_W;
    localparam logic [PAR_W-1:0]  PMAX = {PAR_W{1'b1}};
    localparam logic [PRBS_W-1:0] QMAX = {PRBS_W{1'b1}};

    // R2
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && par_fail && !rd_par && par_cnt != PMAX) |=> par_cnt == $past(par_cnt) + 1'b1);
    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(word_vld && par_fail) && !rd_par) |=> $stable(par_cnt));
    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (par_cnt == PMAX && !rd_par) |=> par_cnt == PMAX);
    // R3
    a_r3_prbs_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_cnt == QMAX && !rd_prbs) |=> prbs_cnt == QMAX);
    // R7
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_par && !(word_vld && par_fail)) |=> par_cnt == '0);
    // R6
    a_r6_prbs_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (prbs_cnt != '0) |-> !err_n);
    // R4, R11
    a_r4_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> err_n == !((par_cnt > $past({lim_hi, lim_lo})) || prbs_cnt != '0));
endmodule

bind vid_parity_mon vpm_checker #(.BYTE_W(BYTE_W), .PRBS_W(PRBS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .par_fail(par_fail),
    .prbs_err(prbs_err), .lim_lo(lim_lo), .lim_hi(lim_hi), .rd_par(rd_par),
    .rd_prbs(rd_prbs), .par_cnt(par_cnt), .prbs_cnt(prbs_cnt), .err_n(err_n)
);

// File: tb/vid_parity_mon_bench.sv
`timescale 1ns/1ps
module vid_parity_mon_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_vld = 0, par_fail = 0, prbs_err = 0, rd_par = 0, rd_prbs = 0;
    logic [7:0] lim_lo = 8'hFF, lim_hi = 8'hFF;
    logic [15:0] par_cnt;
    logic [7:0]  prbs_cnt;
    logic        err_n;

    int n_chk = 0, n_fail = 0;
    int m_par = 0, m_prbs = 0;
    bit m_err_n = 1;
    bit done = 0;

    always #5 clk = ~clk;

    vid_parity_mon u_vid_parity_mon (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .par_fail(par_fail),
        .prbs_err(prbs_err), .lim_lo(lim_lo), .lim_hi(lim_hi), .rd_par(rd_par),
        .rd_prbs(rd_prbs), .par_cnt(par_cnt), .prbs_cnt(prbs_cnt), .err_n(err_n)
    );

    function automatic int next_cnt(int c, bit hit, bit clr, int maxv);
        if (clr) return hit ? 1 : 0;
        if (hit && c < maxv) return c + 1;
        return c;
    endfunction

    function automatic bit exp_err_n(int p, int q, int lim);
        return !((p > lim) || (q != 0));
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " par_cnt"}, par_cnt, m_par);
        check({tag, " prbs_cnt"}, prbs_cnt, m_prbs);
        check({tag, " err_n"}, err_n, m_err_n);
    endtask

    // drive on a negedge, model the edge, and compare at the following negedge
    task automatic step(bit v, bit f, bit p, bit rp, bit rq,
                        logic [7:0] lo, logic [7:0] hi, bit chk, string tag);
        word_vld = v; par_fail = f; prbs_err = p; rd_par = rp; rd_prbs = rq;
        lim_lo = lo; lim_hi = hi;
        @(posedge clk);
        m_par  = next_cnt(m_par, v & f, rp, 65535);
        m_prbs = next_cnt(m_prbs, p, rq, 255);
        m_err_n = exp_err_n(m_par, m_prbs, {hi, lo});
        @(negedge clk);
        word_vld = 0; par_fail = 0; prbs_err = 0; rd_par = 0; rd_prbs = 0;
        if (chk) check_all(tag);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: fail without valid ignored, then counted
        step(0, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R2 fail without valid");
        step(1, 0, 0, 0, 0, 8'd3, 8'd0, 1, "R2 valid without fail");
        step(1, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R2 first error");
        step(1, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R2 second error");
        // R10: burst, idle, burst
        repeat (4) step(0, 0, 0, 0, 0, 8'd3, 8'd0, 1, "R10 idle gap");
        step(1, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R4 equal to limit stays high");
        check("R4 equal limit err_n", err_n, 1);
        step(1, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R4 above limit");
        check("R4 above limit err_n", err_n, 0);
        check("R10 accumulated count", par_cnt, 4);
        // R5 / R11: limit 256 via high byte; flag follows one edge later
        lim_hi = 8'd1; lim_lo = 8'd0;
        #1 check("R11 no combinational path", err_n, 0);
        step(0, 0, 0, 0, 0, 8'd0, 8'd1, 1, "R5 high byte limit");
        check("R5 limit 256 releases", err_n, 1);
        step(0, 0, 0, 0, 0, 8'd3, 8'd0, 1, "R5 low byte limit");
        check("R5 limit 3 asserts", err_n, 0);
        // R7 / R9: read clears, flag releases same cycle
        step(0, 0, 0, 1, 0, 8'd3, 8'd0, 1, "R7 read clears");
        check("R9 release on clear", err_n, 1);
        step(1, 1, 0, 0, 0, 8'd3, 8'd0, 1, "R7 prep");
        step(1, 1, 0, 1, 0, 8'd3, 8'd0, 1, "R7 read with error");
        check("R7 simultaneous gives 1", par_cnt, 1);
        // R6 / R8
        step(0, 0, 1, 0, 0, 8'd3, 8'd0, 1, "R6 pattern error");
        check("R6 flag low", err_n, 0);
        step(0, 0, 1, 0, 1, 8'd3, 8'd0, 1, "R8 read with error");
        check("R8 simultaneous gives 1", prbs_cnt, 1);
        step(0, 0, 0, 0, 1, 8'd3, 8'd0, 1, "R8 read clears");
        check("R9 release after pattern clear", err_n, 1);
        // R9: two causes, clear one
        repeat (5) step(1, 1, 1, 0, 0, 8'd3, 8'd0, 1, "R9 both causes");
        step(0, 0, 0, 1, 0, 8'd3, 8'd0, 1, "R9 clear parity only");
        check("R9 other cause keeps flag", err_n, 0);
        step(0, 0, 0, 0, 1, 8'd3, 8'd0, 1, "R9 clear last cause");
        check("R9 last cause gone", err_n, 1);
        // R3: pattern saturation
        repeat (300) step(0, 0, 1, 0, 0, 8'd3, 8'd0, 0, "R3");
        check_all("R3 pattern saturation");
        check("R3 pattern stops at 255", prbs_cnt, 255);
        step(0, 0, 0, 0, 1, 8'hFF, 8'hFF, 1, "R3 pattern clear");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] lo, hi;
            lo = ($urandom % 4 == 0) ? 8'($urandom) : lim_lo;
            hi = ($urandom % 8 == 0) ? 8'($urandom % 2) : 8'h00;
            step($urandom % 2, $urandom % 3 != 0, $urandom % 10 == 0,
                 $urandom % 20 == 0, $urandom % 12 == 0, lo, hi, 1, "R2 R4 R6 R7 random");
        end
        // R3: parity saturation with limit all ones
        step(0, 0, 0, 1, 1, 8'hFF, 8'hFF, 1, "R3 prep");
        repeat (65600) step(1, 1, 0, 0, 0, 8'hFF, 8'hFF, 0, "R3");
        check_all("R3 parity saturation");
        check("R3 parity stops at 65535", par_cnt, 65535);
        check("R4 count equals max limit", err_n, 1);
        step(1, 1, 0, 0, 0, 8'hFE, 8'hFF, 1, "R4 limit one below max");
        check("R4 flag at 65535 over 65534", err_n, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule